// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the state update of a vector "set length" configuration instruction. Each accepted request brings a proposed vector type word (taken from a register or an immediate), the value of the first source register, and the destination and first-source register specifiers. The unit checks whether the type word is legal. It derives the largest element count that a register group can hold for that element width and group multiplier, on an implementation with a vector register length of `VLEN` bits. It then updates the architectural length (`vl`) and type (`vtype`) registers in one clock.

The requested length depends on the specifiers. When the destination and the source are both register zero, the current length is reused. When only the source is register zero, the request is the largest possible value. In every other case the request is the source register value. The new length is returned for write-back to the destination register. A dirty pulse marks the vector state as modified. An illegal type word sets only the illegal flag of `vtype` and forces the length to zero.

Top module: `vlcfg_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vtype_q` becomes a word with only bit XLEN-1 set, `vl_q` becomes 0, and `wb_en` and `vs_dirty` become 0.
- R2: Type word layout: bits [2:0] are the group multiplier code, bits [5:3] the width code, bits 6 and 7 are policy flags carried unchanged, bits [9:8] the element-divide field, bits [XLEN-2:10] reserved, and bit XLEN-1 the illegal flag. The element width is 8 shifted left by the width code.
- R3: For a legal type, the maximum length is VLEN × multiplier / element width. Multiplier codes 0..3 mean ×1, ×2, ×4, ×8 and codes 5, 6, 7 mean ×1/8, ×1/4, ×1/2. `vl_q` becomes the smaller of the request and the maximum, and `vtype_q` becomes the type word.
- R4: A type word is illegal when the element width exceeds ELEN, when its illegal flag is set, when the element-divide field is nonzero, when any reserved bit is set, or when the multiplier code is 4.
- R5: For a fractional multiplier code m (5, 6 or 7), the type word is illegal when ELEN shifted right by (8 - m) is less than the element width.
- R6: After an illegal type word, `vtype_q` holds only bit XLEN-1 set and `vl_q` is 0.
- R7: With destination and source specifiers both zero, the request equals the current `vl_q`, and `cfg_avl` is ignored.
- R8: With the source specifier zero and the destination nonzero, the request is the largest possible value, so `vl_q` becomes the maximum length.
- R9: In the cycle after an accepted request, `vs_dirty` is 1, `wb_rd` equals the destination specifier, `wb_data` equals the new `vl_q` zero-extended, and `wb_en` is 1 exactly when the destination specifier is nonzero.
- R10: A cycle with `cfg_valid` low leaves `vl_q` and `vtype_q` unchanged and holds `wb_en` and `vs_dirty` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Request strobe, one request per cycle |
| cfg_rd | input | REGW | Destination register specifier |
| cfg_rs1 | input | REGW | First-source register specifier |
| cfg_avl | input | XLEN | Value of the first-source register |
| cfg_vtype | input | XLEN | Proposed type word |
| vl_q | output | $clog2(VLEN)+1 | Current vector length |
| vtype_q | output | XLEN | Current vector type |
| wb_en | output | 1 | Write-back enable for the destination register |
| wb_rd | output | REGW | Write-back register specifier |
| wb_data | output | XLEN | Write-back value (new length) |
| vs_dirty | output | 1 | Vector state modified pulse |

## Verification
All results of a request appear one clock edge after the edge that samples `cfg_valid`: the `vl_q` and `vtype_q` registers, the write-back triple and the dirty pulse. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It then checks every output at that falling edge, which lies between the edge that loaded the result and the edge that clears the pulses. Requests that reuse the current length depend on the previous vector, so the vector table runs in a fixed order and each expected length accounts for the one before it.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   // Group multiplier codes (bits [2:0] of the type word)
   typedef enum logic [2:0] {
      MUL_X1  = 3'd0,
      MUL_X2  = 3'd1,
      MUL_X4  = 3'd2,
      MUL_X8  = 3'd3,
      MUL_RSV = 3'd4,
      MUL_F8  = 3'd5,
      MUL_F4  = 3'd6,
      MUL_F2  = 3'd7
   } mul_code_e;

   // Field positions inside the type word
   localparam int MUL_LSB  = 0;
   localparam int WID_LSB  = 3;
   localparam int EDIV_LSB = 8;
   localparam int RSV_LSB  = 10;

   // log2(multiplier) + 3, so that x1/8 maps to 0 and x8 maps to 6.
   // The reserved code maps to 0; its result is discarded anyway.
   function automatic logic [2:0] mul_shift(input logic [2:0] code);
      if (code == MUL_RSV)
         return 3'd0;
      else if (code[2])
         return code - 3'd5;
      else
         return code + 3'd3;
   endfunction

   function automatic logic is_fractional(input logic [2:0] code);
      return code[2] && (code != MUL_RSV);
   endfunction

endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check
   import vcfg_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int ELEN = 64
) (
   input  logic [2:0]       mul,
   input  logic [2:0]       wid,
   input  logic [1:0]       ediv,
   input  logic [XLEN-12:0] rsv,
   input  logic             ill_flag,
   output logic             illegal
);
   localparam logic [11:0] ELEN_V = 12'(ELEN);

   logic [11:0] sew;
   logic        too_wide;
   logic        frac_bad;
   logic        field_bad;
   logic [11:0] frac_limit;
   logic [3:0]  frac_shift;

   always_comb begin
      sew        = 12'd8 << wid;
      too_wide   = sew > ELEN_V;
      frac_shift = 4'd8 - {1'b0, mul};
      frac_limit = ELEN_V >> frac_shift;
      frac_bad   = 1'b0;
      if (mul == MUL_RSV)
         frac_bad = 1'b1;
      else if (is_fractional(mul))
         frac_bad = frac_limit < sew;
      field_bad  = ill_flag || (ediv != 2'd0) || (|rsv);
      illegal    = too_wide || frac_bad || field_bad;
   end

   // Local guards on the legality decision
   always_comb begin
      if (!$isunknown({mul, wid, ediv, rsv, ill_flag})) begin
         p_rsv_mul_r4 : assert ((mul != MUL_RSV) || illegal)
            else $error("reserved multiplier code accepted");
         p_flag_r4 : assert (!ill_flag || illegal)
            else $error("illegal flag on input not honoured");
         p_e8_int_ok_r5 : assert (!(wid == 3'd0 && !mul[2] && ediv == 2'd0
                                    && !(|rsv) && !ill_flag) || !illegal)
            else $error("plain 8-bit integer-multiplier type rejected");
      end
   end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
   import vcfg_pkg::*;
#(
   parameter int VLEN = 128
) (
   input  logic [2:0]                 mul,
   input  logic [2:0]                 wid,
   output logic [$clog2(VLEN):0]      vlmax
);
   localparam int LOG2V = $clog2(VLEN);
   localparam int VLW   = LOG2V + 1;
   localparam int BW    = LOG2V + 7;

   // VLEN * 2^(log2(mult)+3), later divided by 2^(3+width_code+3)
   logic [BW-1:0]  scaled;
   logic [VLW-1:0] per_wid [8];

   assign scaled = BW'(VLEN) << mul_shift(mul);

   // One shifter tap per width code; the width code picks the tap
   for (genvar w = 0; w < 8; w++) begin : g_wid
      assign per_wid[w] = VLW'(scaled >> (6 + w));
   end

   assign vlmax = per_wid[wid];

   always_comb begin
      if (!$isunknown({mul, wid})) begin
         p_vlmax_cap_r3 : assert (vlmax <= VLW'(VLEN))
            else $error("maximum length above VLEN");
         p_x8_e8_r3 : assert (!(mul == MUL_X8 && wid == 3'd0) || vlmax == VLW'(VLEN))
            else $error("x8 at 8-bit width must equal VLEN");
      end
   end

endmodule

// File: rtl/vcfg_avl_sel.sv
module vcfg_avl_sel #(
   parameter int XLEN = 32,
   parameter int VLW  = 8,
   parameter int REGW = 5
) (
   input  logic [REGW-1:0] rd,
   input  logic [REGW-1:0] rs1,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [VLW-1:0]  cur_vl,
   output logic [XLEN-1:0] avl
);
   typedef enum logic [1:0] {
      SRC_KEEP = 2'd0,
      SRC_MAX  = 2'd1,
      SRC_REG  = 2'd2
   } avl_src_e;

   avl_src_e src;

   always_comb begin
      if (rs1 == '0 && rd == '0)
         src = SRC_KEEP;
      else if (rs1 == '0)
         src = SRC_MAX;
      else
         src = SRC_REG;

      unique case (src)
         SRC_KEEP: avl = XLEN'(cur_vl);
         SRC_MAX:  avl = '1;
         default:  avl = rs1_val;
      endcase
   end

   always_comb begin
      if (!$isunknown({rd, rs1, cur_vl})) begin
         p_keep_r7 : assert (!(rd == '0 && rs1 == '0) || avl == XLEN'(cur_vl))
            else $error("keep-length request not taken from current vl");
         p_max_r8 : assert (!(rd != '0 && rs1 == '0) || (&avl))
            else $error("maximum request not all ones");
      end
   end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
   import vcfg_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int VLEN = 128,
   parameter int ELEN = 64,
   parameter int REGW = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_valid,
   input  logic [REGW-1:0]           cfg_rd,
   input  logic [REGW-1:0]           cfg_rs1,
   input  logic [XLEN-1:0]           cfg_avl,
   input  logic [XLEN-1:0]           cfg_vtype,
   output logic [$clog2(VLEN):0]     vl_q,
   output logic [XLEN-1:0]           vtype_q,
   output logic                      wb_en,
   output logic [REGW-1:0]           wb_rd,
   output logic [XLEN-1:0]           wb_data,
   output logic                      vs_dirty
);
   localparam int VLW = $clog2(VLEN) + 1;
   localparam logic [XLEN-1:0] ILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

   // Elaboration-time parameter checks
   if (VLEN < 8 || (VLEN & (VLEN - 1)) != 0) begin : g_bad_vlen
      $error("VLEN must be a power of two, at least 8");
   end
   if (ELEN < 8 || ELEN > VLEN || (ELEN & (ELEN - 1)) != 0) begin : g_bad_elen
      $error("ELEN must be a power of two between 8 and VLEN");
   end
   if (XLEN < 12 || XLEN < VLW) begin : g_bad_xlen
      $error("XLEN too small for the type word or the length");
   end
   if (REGW < 1) begin : g_bad_regw
      $error("REGW must be positive");
   end

   logic             illegal;
   logic [VLW-1:0]   vlmax;
   logic [XLEN-1:0]  avl;
   logic [VLW-1:0]   vl_nxt;
   logic [XLEN-1:0]  vtype_nxt;

   vcfg_type_check #(.XLEN(XLEN), .ELEN(ELEN)) u_check (
      .mul      (cfg_vtype[MUL_LSB +: 3]),
      .wid      (cfg_vtype[WID_LSB +: 3]),
      .ediv     (cfg_vtype[EDIV_LSB +: 2]),
      .rsv      (cfg_vtype[XLEN-2:RSV_LSB]),
      .ill_flag (cfg_vtype[XLEN-1]),
      .illegal  (illegal)
   );

   vcfg_vlmax #(.VLEN(VLEN)) u_vlmax (
      .mul   (cfg_vtype[MUL_LSB +: 3]),
      .wid   (cfg_vtype[WID_LSB +: 3]),
      .vlmax (vlmax)
   );

   vcfg_avl_sel #(.XLEN(XLEN), .VLW(VLW), .REGW(REGW)) u_avl (
      .rd      (cfg_rd),
      .rs1     (cfg_rs1),
      .rs1_val (cfg_avl),
      .cur_vl  (vl_q),
      .avl     (avl)
   );

   always_comb begin
      if (illegal) begin
         vl_nxt    = '0;
         vtype_nxt = ILL_WORD;
      end else begin
         vl_nxt    = (avl < XLEN'(vlmax)) ? VLW'(avl) : vlmax;
         vtype_nxt = {1'b0, cfg_vtype[XLEN-2:0]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q     <= '0;
         vtype_q  <= ILL_WORD;
         wb_en    <= 1'b0;
         wb_rd    <= '0;
         wb_data  <= '0;
         vs_dirty <= 1'b0;
      end else begin
         wb_en    <= cfg_valid && (cfg_rd != '0);
         vs_dirty <= cfg_valid;
         if (cfg_valid) begin
            vl_q    <= vl_nxt;
            vtype_q <= vtype_nxt;
            wb_rd   <= cfg_rd;
            wb_data <= XLEN'(vl_nxt);
         end
      end
   end

   // Clocked checks on the architectural state
   p_cap_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= VLW'(VLEN))
      else $error("vl above VLEN");

   p_ill_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      vtype_q[XLEN-1] |-> (vl_q == '0) && (vtype_q[XLEN-2:0] == '0))
      else $error("illegal vtype with nonzero vl or fields");

   p_dirty_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> vs_dirty)
      else $error("accepted request without dirty pulse");

   p_wb_match_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> vs_dirty && (wb_data == XLEN'(vl_q)))
      else $error("write-back value differs from vl");

   p_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |=> $stable(vl_q) && $stable(vtype_q) && !vs_dirty && !wb_en)
      else $error("state moved without a request");

endmodule

// File: tb/sim_vlcfg_unit.sv
`timescale 1ns/1ps
module sim_vlcfg_unit;
   localparam int XLEN = 32;
   localparam int VLEN = 128;
   localparam int ELEN = 64;
   localparam int REGW = 5;
   localparam int VLW  = $clog2(VLEN) + 1;
   localparam logic [31:0] ILL = 32'h8000_0000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic [REGW-1:0]  cfg_rd = '0;
   logic [REGW-1:0]  cfg_rs1 = '0;
   logic [XLEN-1:0]  cfg_avl = '0;
   logic [XLEN-1:0]  cfg_vtype = '0;
   logic [VLW-1:0]   vl_q;
   logic [XLEN-1:0]  vtype_q;
   logic             wb_en;
   logic [REGW-1:0]  wb_rd;
   logic [XLEN-1:0]  wb_data;
   logic             vs_dirty;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   vlcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN), .REGW(REGW)) u0 (
      .clk, .rst_n, .cfg_valid, .cfg_rd, .cfg_rs1, .cfg_avl, .cfg_vtype,
      .vl_q, .vtype_q, .wb_en, .wb_rd, .wb_data, .vs_dirty
   );

   typedef struct packed {
      logic [4:0]  rd;
      logic [4:0]  rs1;
      logic [31:0] avl;
      logic [31:0] vt;
      logic [7:0]  evl;
      logic [31:0] evt;
      logic        ewen;
   } vec_t;

   // Type word: [2:0] multiplier, [5:3] width, 7:6 policy, [9:8] divide, 31 illegal
   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{5'd1, 5'd2, 32'd10,   32'h00,  8'd10, 32'h00, 1'b1}, // R3 e8 x1 under max
      '{5'd1, 5'd2, 32'd100,  32'h00,  8'd16, 32'h00, 1'b1}, // R3 clamp to 16
      '{5'd2, 5'd3, 32'd1000, 32'h0B,  8'd64, 32'h0B, 1'b1}, // R3 e16 x8
      '{5'd1, 5'd2, 32'd7,    32'h1F,  8'd0,  ILL,    1'b1}, // R5 e64 x1/2
      '{5'd1, 5'd2, 32'd5,    32'h17,  8'd2,  32'h17, 1'b1}, // R5 e32 x1/2 legal
      '{5'd1, 5'd2, 32'd1,    32'h05,  8'd1,  32'h05, 1'b1}, // R5 e8 x1/8 legal
      '{5'd1, 5'd2, 32'd9,    32'h0D,  8'd0,  ILL,    1'b1}, // R5 e16 x1/8
      '{5'd1, 5'd2, 32'd9,    32'h04,  8'd0,  ILL,    1'b1}, // R4 code 4
      '{5'd1, 5'd2, 32'd9,    32'h20,  8'd0,  ILL,    1'b1}, // R4 width 128 > ELEN
      '{5'd1, 5'd2, 32'd9,    32'h100, 8'd0,  ILL,    1'b1}, // R4 divide field
      '{5'd1, 5'd2, 32'd9,    32'h400, 8'd0,  ILL,    1'b1}, // R4 reserved bit
      '{5'd1, 5'd2, 32'd9,    ILL,     8'd0,  ILL,    1'b1}, // R4 illegal flag in
      '{5'd4, 5'd5, 32'd8,    32'hD1,  8'd8,  32'hD1, 1'b1}, // R2 policy bits kept, e32 x2
      '{5'd3, 5'd0, 32'd99,   32'h02,  8'd64, 32'h02, 1'b1}, // R8 max e8 x4
      '{5'd0, 5'd0, 32'd99,   32'h0A,  8'd32, 32'h0A, 1'b0}, // R7 keep 64, clamp 32
      '{5'd0, 5'd0, 32'd99,   32'h03,  8'd32, 32'h03, 1'b0}, // R7 keep 32 under max 128
      '{5'd1, 5'd2, 32'd9,    32'h04,  8'd0,  ILL,    1'b1}, // R6 illegal again
      '{5'd0, 5'd0, 32'd99,   32'h00,  8'd0,  32'h00, 1'b0}, // R7 keep 0
      '{5'd0, 5'd6, 32'd3,    32'h00,  8'd3,  32'h00, 1'b0}, // R9 rd zero, no write
      '{5'd7, 5'd8, 32'd16,   32'h00,  8'd16, 32'h00, 1'b1}, // R3 request equals max
      '{5'd7, 5'd8, 32'd0,    32'h00,  8'd0,  32'h00, 1'b1}  // R3 request zero
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic request(input vec_t v);
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_rd    = v.rd;
      cfg_rs1   = v.rs1;
      cfg_avl   = v.avl;
      cfg_vtype = v.vt;
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_avl   = 32'hDEAD_BEEF;
   endtask

   initial begin : main
      string tag;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "vl", 32'(vl_q), 32'd0);
      check("R1", "vtype", vtype_q, ILL);
      check("R1", "wb_en", 32'(wb_en), 32'd0);
      check("R1", "dirty", 32'(vs_dirty), 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         request(TBL[i]);
         if (TBL[i].evt == ILL)                    tag = "R6";
         else if (TBL[i].rs1 == 0 && TBL[i].rd == 0) tag = "R7";
         else if (TBL[i].rs1 == 0)                 tag = "R8";
         else                                      tag = "R3";
         check(tag, $sformatf("vec%0d vl", i), 32'(vl_q), 32'(TBL[i].evl));
         check(tag, $sformatf("vec%0d vtype", i), vtype_q, TBL[i].evt);
         check("R9", $sformatf("vec%0d wb_en", i), 32'(wb_en), 32'(TBL[i].ewen));
         check("R9", $sformatf("vec%0d wb_data", i), wb_data, 32'(TBL[i].evl));
         check("R9", $sformatf("vec%0d wb_rd", i), 32'(wb_rd), 32'(TBL[i].rd));
         check("R9", $sformatf("vec%0d dirty", i), 32'(vs_dirty), 32'd1);
      end

      // R10: junk inputs with strobe low change nothing (last state vl 0, vtype 0)
      @(negedge clk);
      cfg_rd = 5'd9; cfg_rs1 = 5'd0; cfg_vtype = 32'h03;
      repeat (3) @(negedge clk);
      check("R10", "vl", 32'(vl_q), 32'd0);
      check("R10", "vtype", vtype_q, 32'h00);
      check("R10", "wb_en", 32'(wb_en), 32'd0);
      check("R10", "dirty", 32'(vs_dirty), 32'd0);

      // R8 after idle: establishes nonzero state, then R1 reset mid-run
      request('{5'd9, 5'd0, 32'd0, 32'h03, 8'd128, 32'h03, 1'b1});
      check("R8", "vl e8 x8", 32'(vl_q), 32'd128);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "vl after reset", 32'(vl_q), 32'd0);
      check("R1", "vtype after reset", vtype_q, ILL);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule